// File: doc/BRIEF.md
# Y86 Execute-Stage ALU and Condition Codes

This block is the arithmetic heart of a Y86-style execute stage. It combines two 64-bit operands under a 4-bit function code and returns the result, valE, in the same cycle. It keeps the zero, sign and overflow flags in a small register that changes only when an OPq or halt instruction is strobed. A condition evaluator reads the stored flags and turns a 3-bit condition selector into the single `cnd` bit that conditional moves and jumps use.

The operand fed to `src_val` is the source register value (valA) and `dst_val` is the destination register value (valB). Subtraction is destination minus source. Add and subtract are signed two's-complement operations, so only they can set overflow. The logical operations always clear it. The fetch logic, register file, memory, PC update and I/O traps sit outside this block.

Top module: `y86_exec_alu`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, `zf`, `sf` and `of` become 0.
- R2: `val_e` is combinational in the function code, modulo 2^64. Code 0 gives `dst_val + src_val`, code 1 gives `dst_val - src_val`, code 2 gives `dst_val & src_val` and code 3 gives `dst_val ^ src_val`. Codes 4 to 15 give 0.
- R3: An OPq strobe with a valid code (0..3) and no halt sets the flags at the next rising edge. `zf` becomes 1 exactly when the 64-bit result is zero, and `sf` takes result bit 63.
- R4: For an add, `of` becomes 1 when both operands have the same sign and the result's sign differs from it. For AND and XOR, `of` becomes 0.
- R5: For a subtract, `of` becomes 1 in two cases: the subtrahend `src_val` is positive and the result is greater than the minuend `dst_val`, or the subtrahend is negative and the result is less than the minuend. The comparisons are signed.
- R6: A halt strobe clears all three flags at the next edge. When halt and OPq are strobed together, halt wins.
- R7: With neither strobe high, the flags keep their values across the edge.
- R8: `bad_fn` is high exactly when `is_opq` is high and the code is outside 0..3. Such an OPq leaves the flags unchanged.
- R9: `cnd` is combinational in `cond_sel` and the stored flags. Code 0 gives 1, code 3 gives `zf`, and code 4 gives not `zf`.
- R10: Let lt = `sf` xor `of`. Code 2 gives lt, code 1 gives lt or `zf`, code 5 gives not lt, code 6 gives not (lt or `zf`), and code 7 gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| src_val | input | 64 | Source operand (valA) |
| dst_val | input | 64 | Destination operand (valB) |
| alu_fn | input | 4 | Operation code for OPq |
| is_opq | input | 1 | Current instruction is an OPq |
| is_halt | input | 1 | Current instruction is a halt |
| cond_sel | input | 3 | Condition selector for cnd |
| val_e | output | 64 | Combinational ALU result |
| bad_fn | output | 1 | OPq with an undefined function code |
| cnd | output | 1 | Evaluated condition from the stored flags |
| zf | output | 1 | Stored zero flag |
| sf | output | 1 | Stored sign flag |
| of | output | 1 | Stored overflow flag |

## Verification
The directed patterns each isolate one part of the flag logic:
- A small sum with a clean result checks the ordinary case.
- Sums at the positive and negative limits separate a genuine overflow from a plain carry out.
- Subtractions whose subtrahend is positive, negative, zero or the most negative value separate the signed overflow rule from an unsigned borrow.
- An AND or XOR issued right after an overflow shows that O is actively cleared, not merely kept.

Further patterns separate an update from a hold:
- Undefined codes, cycles with no strobe, and a halt given together with an OPq each follow a cycle that left the flags nonzero.

A sweep of all eight condition codes over flag states built from these results, followed by a long run of mixed random operations, checks `cnd` against every combination of Z, S and O.

// File: rtl/y86alu_pkg.sv
// Package: shared widths, operation and condition encodings, flag type
// for the Y86 execute-stage ALU.
package y86alu_pkg;

    parameter int unsigned DATA_W = 64;
    parameter int unsigned FN_W   = 4;
    parameter int unsigned COND_W = 3;

    // OPq function codes
    typedef enum logic [FN_W-1:0] {
        FN_ADD = 4'd0,
        FN_SUB = 4'd1,
        FN_AND = 4'd2,
        FN_XOR = 4'd3
    } alu_fn_e;

    // Condition selector codes for moves and jumps
    typedef enum logic [COND_W-1:0] {
        CC_ALWAYS = 3'd0,
        CC_LE     = 3'd1,
        CC_LT     = 3'd2,
        CC_EQ     = 3'd3,
        CC_NE     = 3'd4,
        CC_GE     = 3'd5,
        CC_GT     = 3'd6,
        CC_RSVD   = 3'd7
    } cond_e;

    // Stored condition flags
    typedef struct packed {
        logic z;
        logic s;
        logic o;
    } flags_t;

endpackage

// File: rtl/alu_datapath.sv
// Module: alu_datapath
// Combinational OPq datapath. Add and subtract share one adder: subtract
// feeds the inverted source operand with a carry-in of one. The module
// also produces the signed overflow, zero and sign of the result.
// Assumes: op_b is the destination (minuend), op_a is the source.
// Undefined codes yield a zero result, no overflow and fn_ok low.
module alu_datapath
    import y86alu_pkg::*;
#(
    parameter int unsigned DATA_W  = y86alu_pkg::DATA_W,
    parameter int unsigned CHUNK_W = 16
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [FN_W-1:0]   fn,
    output logic [DATA_W-1:0] res,
    output logic              ovf,
    output logic              fn_ok,
    output logic              is_zero,
    output logic              is_neg
);

    localparam int unsigned MSB     = DATA_W - 1;
    localparam int unsigned N_CHUNK = (DATA_W + CHUNK_W - 1) / CHUNK_W;
    localparam int unsigned PAD_W   = N_CHUNK * CHUNK_W;

    logic              sub_sel;
    logic [DATA_W-1:0] addend;
    logic [DATA_W-1:0] sum;
    logic              sum_ovf;
    logic [PAD_W-1:0]  res_pad;
    logic [N_CHUNK-1:0] chunk_nz;

    // Shared adder: subtract turns into b + ~a + 1
    always_comb begin
        sub_sel = (fn == FN_SUB);
        addend  = sub_sel ? ~op_a : op_a;
        sum     = op_b + addend + {{(DATA_W-1){1'b0}}, sub_sel};
        sum_ovf = (op_b[MSB] == addend[MSB]) && (sum[MSB] != op_b[MSB]);
    end

    // Result and overflow selection by function code
    always_comb begin
        fn_ok = 1'b1;
        res   = '0;
        ovf   = 1'b0;
        case (fn)
            FN_ADD, FN_SUB: begin
                res = sum;
                ovf = sum_ovf;
            end
            FN_AND: res = op_b & op_a;
            FN_XOR: res = op_b ^ op_a;
            default: fn_ok = 1'b0;
        endcase
    end

    // Pad the result to a whole number of chunks for zero detection
    always_comb begin
        res_pad             = '0;
        res_pad[DATA_W-1:0] = res;
    end

    // Zero detection as a two-level OR tree over fixed-size chunks
    for (genvar g = 0; g < N_CHUNK; g++) begin : g_zchunk
        assign chunk_nz[g] = |res_pad[g*CHUNK_W +: CHUNK_W];
    end

    assign is_zero = ~|chunk_nz;
    assign is_neg  = res[MSB];

endmodule

// File: rtl/flag_reg.sv
// Module: flag_reg
// Condition-flag register. On each rising edge a halt clears all flags,
// a valid OPq loads fresh flags, and anything else holds them.
// Assumes: nxt_o is already zero for logical operations; reset is
// synchronous and active low.
module flag_reg
    import y86alu_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   is_opq,
    input  logic   is_halt,
    input  logic   fn_ok,
    input  logic   logic_op,
    input  logic   nxt_z,
    input  logic   nxt_s,
    input  logic   nxt_o,
    output flags_t flags
);

    // Flag update with halt priority over OPq
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else if (is_halt) begin
            flags <= '0;
        end else if (is_opq && fn_ok) begin
            flags <= '{z: nxt_z, s: nxt_s, o: nxt_o};
        end
    end

    // R6: halt clears every flag
    p_halt_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        is_halt |=> (flags == '0));

    // R7: no strobe keeps flags
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_halt && !is_opq) |=> $stable(flags));

    // R4: logical operations leave O clear
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_opq && !is_halt && fn_ok && logic_op) |=> !flags.o);

endmodule

// File: rtl/cond_eval.sv
// Module: cond_eval
// Turns the stored flags and a 3-bit selector into the cnd bit.
// Assumes: signed comparisons follow lt = S xor O; the reserved code
// evaluates false.
module cond_eval
    import y86alu_pkg::*;
(
    input  flags_t            flags,
    input  logic [COND_W-1:0] cond,
    output logic              cnd
);

    logic lt;
    logic le;

    // Derived signed relations
    always_comb begin
        lt = flags.s ^ flags.o;
        le = lt | flags.z;
    end

    // Selector decode
    always_comb begin
        case (cond)
            CC_ALWAYS: cnd = 1'b1;
            CC_LE:     cnd = le;
            CC_LT:     cnd = lt;
            CC_EQ:     cnd = flags.z;
            CC_NE:     cnd = ~flags.z;
            CC_GE:     cnd = ~lt;
            CC_GT:     cnd = ~le;
            default:   cnd = 1'b0;
        endcase
    end

endmodule

// File: rtl/y86_exec_alu.sv
// Module: y86_exec_alu (top)
// Execute-stage ALU with stored condition flags and a condition evaluator.
// Assumes: at most one instruction per cycle. When is_opq and is_halt
// are both high, halt wins. val_e, bad_fn and cnd are combinational.
module y86_exec_alu
    import y86alu_pkg::*;
#(
    parameter int unsigned DATA_W = y86alu_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] src_val,
    input  logic [DATA_W-1:0] dst_val,
    input  logic [FN_W-1:0]   alu_fn,
    input  logic              is_opq,
    input  logic              is_halt,
    input  logic [COND_W-1:0] cond_sel,
    output logic [DATA_W-1:0] val_e,
    output logic              bad_fn,
    output logic              cnd,
    output logic              zf,
    output logic              sf,
    output logic              of
);

    logic   fn_ok;
    logic   res_ovf;
    logic   res_zero;
    logic   res_neg;
    logic   logic_op;
    flags_t flags;

    alu_datapath #(.DATA_W(DATA_W)) u_dp (
        .op_a    (src_val),
        .op_b    (dst_val),
        .fn      (alu_fn),
        .res     (val_e),
        .ovf     (res_ovf),
        .fn_ok   (fn_ok),
        .is_zero (res_zero),
        .is_neg  (res_neg)
    );

    // Logical-operation indicator for the flag checker
    always_comb logic_op = (alu_fn == FN_AND) || (alu_fn == FN_XOR);

    flag_reg u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .is_opq   (is_opq),
        .is_halt  (is_halt),
        .fn_ok    (fn_ok),
        .logic_op (logic_op),
        .nxt_z    (res_zero),
        .nxt_s    (res_neg),
        .nxt_o    (res_ovf),
        .flags    (flags)
    );

    cond_eval u_cond (
        .flags (flags),
        .cond  (cond_sel),
        .cnd   (cnd)
    );

    // Output mapping
    always_comb begin
        bad_fn = is_opq & ~fn_ok;
        zf     = flags.z;
        sf     = flags.s;
        of     = flags.o;
    end

    // R8: an undefined code keeps the flags
    p_bad_fn_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_opq && !is_halt && bad_fn) |=> $stable({zf, sf, of}));

    // R3: Z and S follow the result that was presented
    p_zero_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_opq && !is_halt && !bad_fn) |=>
            ((zf == ($past(val_e) == '0)) && (sf == $past(val_e[DATA_W-1]))));

    // R9: the always code is true
    p_always_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_sel == 3'd0) |-> cnd);

    // R9: the equal code tracks Z
    p_equal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_sel == 3'd3) |-> (cnd == zf));

    // R10: the reserved code is false
    p_reserved_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_sel == 3'd7) |-> !cnd);

endmodule

// File: tb/y86_exec_alu_bench.sv
// Bench: behavioural reference model compared on every clock.
module y86_exec_alu_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src_val = '0;
    logic [63:0] dst_val = '0;
    logic [3:0]  alu_fn = '0;
    logic        is_opq = 1'b0;
    logic        is_halt = 1'b0;
    logic [2:0]  cond_sel = '0;
    logic [63:0] val_e;
    logic        bad_fn, cnd, zf, sf, of;

    int checks = 0;
    int errors = 0;
    bit mz = 0, ms = 0, mo = 0;   // model flags

    localparam logic [63:0] MAXP = 64'h7fff_ffff_ffff_ffff;
    localparam logic [63:0] MINN = 64'h8000_0000_0000_0000;

    always #4 clk = ~clk;   // 125 MHz

    y86_exec_alu u_y86_exec_alu (
        .clk(clk), .rst_n(rst_n), .src_val(src_val), .dst_val(dst_val),
        .alu_fn(alu_fn), .is_opq(is_opq), .is_halt(is_halt),
        .cond_sel(cond_sel), .val_e(val_e), .bad_fn(bad_fn), .cnd(cnd),
        .zf(zf), .sf(sf), .of(of)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_result(input logic [3:0] f,
            input logic [63:0] a, input logic [63:0] b);
        case (f)
            4'd0: return b + a;
            4'd1: return b - a;
            4'd2: return b & a;
            4'd3: return b ^ a;
            default: return 64'd0;
        endcase
    endfunction

    function automatic bit ref_ovf(input logic [3:0] f,
            input logic [63:0] a, input logic [63:0] b);
        logic signed [63:0] sa, sb, sr;
        logic signed [64:0] wide;
        sa = a; sb = b;
        if (f == 4'd0) begin
            sr = b + a;
            wide = {sb[63], sb} + {sa[63], sa};
            return wide != {sr[63], sr};
        end
        if (f == 4'd1) begin
            sr = b - a;
            return (sa > 0 && sr > sb) || (sa < 0 && sr < sb);
        end
        return 1'b0;
    endfunction

    function automatic bit ref_cnd(input logic [2:0] c);
        bit lt;
        lt = ms ^ mo;
        case (c)
            3'd0: return 1'b1;
            3'd1: return lt || mz;
            3'd2: return lt;
            3'd3: return mz;
            3'd4: return !mz;
            3'd5: return !lt;
            3'd6: return !(lt || mz);
            default: return 1'b0;
        endcase
    endfunction

    // One instruction: drive, check combinational outputs, clock, check flags
    task automatic step(input logic [63:0] a, input logic [63:0] b,
                        input logic [3:0] f, input bit opq, input bit hlt,
                        input logic [2:0] c, input string req);
        logic [63:0] r;
        string cr;
        src_val = a; dst_val = b; alu_fn = f;
        is_opq = opq; is_halt = hlt; cond_sel = c;
        #2;
        r = ref_result(f, a, b);
        cr = (c == 3'd0 || c == 3'd3 || c == 3'd4) ? "R9" : "R10";
        check("R2", "val_e", val_e, r);
        check("R8", "bad_fn", {63'd0, bad_fn}, {63'd0, opq && f > 4'd3});
        check(cr, "cnd", {63'd0, cnd}, {63'd0, ref_cnd(c)});
        @(posedge clk);
        if (hlt) begin
            mz = 0; ms = 0; mo = 0;
        end else if (opq && f <= 4'd3) begin
            mz = (r == 64'd0);
            ms = r[63];
            mo = ref_ovf(f, a, b);
        end
        #1;
        check(req, "flags{z,s,o}", {61'd0, zf, sf, of}, {61'd0, mz, ms, mo});
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        is_opq = 1'b0; is_halt = 1'b0;
        @(posedge clk); #1;
        mz = 0; ms = 0; mo = 0;
        check("R1", "flags after reset", {61'd0, zf, sf, of}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        do_reset();
        // R3: small sum, clean flags
        step(64'd3, 64'd2, 4'd0, 1, 0, 3'd0, "R3");
        // R4: positive overflow on add
        step(64'd1, MAXP, 4'd0, 1, 0, 3'd2, "R4");
        // R4: negative overflow on add, result zero
        step(MINN, MINN, 4'd0, 1, 0, 3'd2, "R4");
        // R4: carry out without overflow
        step(64'hffff_ffff_ffff_ffff, 64'd1, 4'd0, 1, 0, 3'd3, "R4");
        // R3: subtract equal gives zero
        step(64'd77, 64'd77, 4'd1, 1, 0, 3'd3, "R3");
        // R5: min - 1 overflows (subtrahend positive)
        step(64'd1, MINN, 4'd1, 1, 0, 3'd5, "R5");
        // R4: AND right after overflow clears O
        step(64'hff, 64'hf0f0, 4'd2, 1, 0, 3'd1, "R4");
        // R5: max - (-1) overflows (subtrahend negative)
        step(64'hffff_ffff_ffff_ffff, MAXP, 4'd1, 1, 0, 3'd6, "R5");
        // R4: XOR after overflow clears O, self-XOR gives zero
        step(64'h1234, 64'h1234, 4'd3, 1, 0, 3'd4, "R4");
        // R5: 0 - min overflows; 5 - 0 does not
        step(MINN, 64'd0, 4'd1, 1, 0, 3'd2, "R5");
        // R8: undefined codes keep the flags
        step(64'd5, 64'd9, 4'd4, 1, 0, 3'd1, "R8");
        step(64'd5, 64'd9, 4'd15, 1, 0, 3'd6, "R8");
        // R7: no strobe keeps the flags
        step(64'd1, MAXP, 4'd0, 0, 0, 3'd5, "R7");
        step(64'd0, 64'd0, 4'd7, 0, 0, 3'd7, "R7");
        step(64'd0, 64'd5, 4'd1, 1, 0, 3'd6, "R5");
        step(64'd1, 64'd0, 4'd1, 1, 0, 3'd2, "R3");
        // R6: halt clears, and wins over a simultaneous OPq
        step(64'd0, 64'd0, 4'd0, 1, 1, 3'd1, "R6");
        step(64'd1, MINN, 4'd1, 1, 0, 3'd0, "R5");
        step(64'd0, 64'd0, 4'd0, 0, 1, 3'd5, "R6");
        // R9 and R10: every condition code over several flag states
        for (int k = 0; k < 4; k++) begin
            case (k)
                0: step(64'd0, 64'd0, 4'd3, 1, 0, 3'd0, "R3");
                1: step(64'd1, MINN, 4'd1, 1, 0, 3'd0, "R5");
                2: step(64'd2, 64'd1, 4'd1, 1, 0, 3'd0, "R3");
                default: step(64'd1, MAXP, 4'd0, 1, 0, 3'd0, "R4");
            endcase
            for (int c = 0; c < 8; c++)
                step(64'd0, 64'd0, 4'd0, 0, 0, 3'(c), "R7");
        end
        // R1: reset from nonzero flags
        do_reset();
        // Mixed random run
        for (int i = 0; i < 400; i++) begin
            logic [63:0] a, b;
            logic [3:0]  f;
            int sel;
            sel = $urandom_range(0, 3);
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            if (sel == 0) a = MAXP;
            if (sel == 1) b = MINN;
            if (sel == 2) a = b;
            f = 4'($urandom_range(0, 5));
            step(a, b, f, $urandom_range(0, 9) != 0, $urandom_range(0, 15) == 0,
                 3'($urandom_range(0, 7)), (f == 4'd1) ? "R5" : "R3");
        end
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule